// File: doc/BRIEF.md
# Base Integer ALU

This block is the combinational arithmetic and logic core of a 32-bit integer execute stage. It takes two operands and the instruction's three-bit function field, the bit that picks the alternate form of an operation, and a flag that marks the register-immediate form. It returns one result in the same cycle. The operations are addition, subtraction, signed and unsigned less-than, the three bitwise operations, a left shift, and the two right shifts.

Operand steering, immediate generation and the register file sit outside the block. The surrounding decoder passes the function field and the alternate bit through unchanged, so one instance serves both the register-register and the register-immediate forms. Sums wrap around at the word width and raise no flag. The less-than operations reuse the subtract path. Both shift directions run through one right-shift network.

Top module: `rv_alu`

## Requirements
- R1: With `funct3_i` = 000 and `alt_i` = 0, `result_o` is `op_a_i + op_b_i` modulo 2^32, and no flag or exception is raised.
- R2: With `funct3_i` = 000, `alt_i` = 1 and `imm_form_i` = 0, `result_o` is `op_a_i - op_b_i` modulo 2^32, which equals `op_a_i + ~op_b_i + 1`.
- R3: With `imm_form_i` = 1 and `funct3_i` = 000, the unit adds whatever the value of `alt_i`.
- R4: With `funct3_i` = 010, `result_o` is 1 when `op_a_i` is less than `op_b_i` as two's-complement signed values, and 0 otherwise. Bits 31..1 are zero.
- R5: With `funct3_i` = 011, `result_o` is 1 when `op_a_i` is less than `op_b_i` as unsigned values, and 0 otherwise. Bits 31..1 are zero.
- R6: `funct3_i` = 100 gives XOR, 110 gives OR and 111 gives AND, each bit by bit.
- R7: With `funct3_i` = 001, `result_o` is `op_a_i` shifted left, with zeros filling the vacated low bits. This one left shift serves both signed and unsigned values.
- R8: With `funct3_i` = 101 and `alt_i` = 0, `result_o` is `op_a_i` shifted right, with zeros filling the vacated high bits.
- R9: With `funct3_i` = 101 and `alt_i` = 1, `result_o` is `op_a_i` shifted right, with copies of bit 31 filling the vacated high bits. This holds in both the register and the immediate form.
- R10: Every shift uses only `op_b_i[4:0]` as the shift distance, and `op_b_i[31:5]` has no effect on the result.
- R11: `alt_i` has no effect for every `funct3_i` value other than 000 and 101.
- R12: `result_o` follows its inputs combinationally: a change at an input shows in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 32 | First operand; the value shifted by shift operations |
| op_b_i | input | 32 | Second operand; its low 5 bits are the shift distance |
| funct3_i | input | 3 | Operation class, encoded as in R1 to R9 |
| alt_i | input | 1 | Alternate-form bit: picks subtract or arithmetic right shift |
| imm_form_i | input | 1 | 1 for the register-immediate form, which turns off subtract |
| result_o | output | 32 | Operation result |

## Verification
Two functions share hardware and can meet on one select value. Subtract and the two less-than operations use the same adder in its inverted-operand mode. Logical and arithmetic right shift, and left shift through bit reversal, use the same shifter. The bench drives every funct3/alt/immediate combination against a set of corner operands: zero, one, all ones, the most negative and most positive values, and shift amounts whose upper bits are set. It then adds random operands. Each result is judged against a behavioural model that uses the language's own operators, so errors in the shared carry, in the sign-fill logic, or in the select decode show up as mismatches.

// File: rtl/rv_alu_pkg.sv
`timescale 1ns/1ps
package rv_alu_pkg;

  typedef enum logic [2:0] {
    F3_ADD  = 3'b000,
    F3_SLL  = 3'b001,
    F3_SLT  = 3'b010,
    F3_SLTU = 3'b011,
    F3_XOR  = 3'b100,
    F3_SR   = 3'b101,
    F3_OR   = 3'b110,
    F3_AND  = 3'b111
  } funct3_e;

  typedef enum logic [2:0] {
    SEL_SUM,
    SEL_SHIFT,
    SEL_LT,
    SEL_XOR,
    SEL_OR,
    SEL_AND
  } res_sel_e;

  typedef struct packed {
    logic     invert_b;    // adder runs a + ~b + 1
    logic     cmp_signed;  // pick signed less-than
    logic     shift_right;
    logic     shift_arith;
    res_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/rv_alu_decode.sv
`timescale 1ns/1ps
module rv_alu_decode
  import rv_alu_pkg::*;
(
  input  logic [2:0] funct3_i,
  input  logic       alt_i,
  input  logic       imm_form_i,
  output alu_ctrl_t  ctrl_o
);

  funct3_e f3;
  assign f3 = funct3_e'(funct3_i);

  always_comb begin
    ctrl_o             = '0;
    ctrl_o.sel         = SEL_SUM;
    unique case (f3)
      F3_ADD:  begin
        ctrl_o.sel      = SEL_SUM;
        ctrl_o.invert_b = alt_i & ~imm_form_i;
      end
      F3_SLL:  ctrl_o.sel = SEL_SHIFT;
      F3_SLT:  begin
        ctrl_o.sel        = SEL_LT;
        ctrl_o.invert_b   = 1'b1;
        ctrl_o.cmp_signed = 1'b1;
      end
      F3_SLTU: begin
        ctrl_o.sel      = SEL_LT;
        ctrl_o.invert_b = 1'b1;
      end
      F3_XOR:  ctrl_o.sel = SEL_XOR;
      F3_SR:   begin
        ctrl_o.sel         = SEL_SHIFT;
        ctrl_o.shift_right = 1'b1;
        ctrl_o.shift_arith = alt_i;
      end
      F3_OR:   ctrl_o.sel = SEL_OR;
      F3_AND:  ctrl_o.sel = SEL_AND;
      default: ctrl_o.sel = SEL_SUM;
    endcase
  end

endmodule

// File: rtl/rv_alu_addsub.sv
`timescale 1ns/1ps
module rv_alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  input  logic            invert_b_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);

  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   wide;

  assign b_eff = invert_b_i ? ~op_b_i : op_b_i;
  assign wide  = {1'b0, op_a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, invert_b_i};
  assign sum_o = wide[MSB:0];

  // valid only while invert_b_i is set
  assign lt_u_o = ~wide[XLEN];
  assign lt_s_o = (op_a_i[MSB] ^ op_b_i[MSB]) ? op_a_i[MSB] : wide[MSB];

endmodule

// File: rtl/rv_alu_shift.sv
`timescale 1ns/1ps
module rv_alu_shift #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         val_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  input  logic                    right_i,
  input  logic                    arith_i,
  output logic [XLEN-1:0]         res_o
);

  localparam int SHW = $clog2(XLEN);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] val_rev;
  logic [XLEN-1:0] core_in;
  logic [XLEN-1:0] core_out;
  logic [XLEN-1:0] out_rev;
  logic            fill;
  logic [XLEN-1:0] stg [SHW+1];

  // left shift = reverse, shift right with zero fill, reverse back
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign val_rev[i] = val_i[MSB-i];
    assign out_rev[i] = core_out[MSB-i];
  end

  assign core_in = right_i ? val_i : val_rev;
  assign fill    = right_i & arith_i & val_i[MSB];
  assign stg[0]  = core_in;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = shamt_i[s] ? {{D{fill}}, stg[s][MSB:D]} : stg[s];
  end

  assign core_out = stg[SHW];
  assign res_o    = right_i ? core_out : out_rev;

endmodule

// File: rtl/rv_alu.sv
`timescale 1ns/1ps
module rv_alu
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  input  logic [2:0]      funct3_i,
  input  logic            alt_i,
  input  logic            imm_form_i,
  output logic [XLEN-1:0] result_o
);

  localparam int SHW = $clog2(XLEN);

  alu_ctrl_t       ctrl;
  logic [XLEN-1:0] sum_w;
  logic [XLEN-1:0] shift_w;
  logic            lt_s_w;
  logic            lt_u_w;
  logic            lt_w;

  rv_alu_decode u_dec (
    .funct3_i   (funct3_i),
    .alt_i      (alt_i),
    .imm_form_i (imm_form_i),
    .ctrl_o     (ctrl)
  );

  rv_alu_addsub #(.XLEN(XLEN)) u_add (
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .invert_b_i (ctrl.invert_b),
    .sum_o      (sum_w),
    .lt_s_o     (lt_s_w),
    .lt_u_o     (lt_u_w)
  );

  rv_alu_shift #(.XLEN(XLEN)) u_sh (
    .val_i   (op_a_i),
    .shamt_i (op_b_i[SHW-1:0]),
    .right_i (ctrl.shift_right),
    .arith_i (ctrl.shift_arith),
    .res_o   (shift_w)
  );

  assign lt_w = ctrl.cmp_signed ? lt_s_w : lt_u_w;

  always_comb begin
    unique case (ctrl.sel)
      SEL_SUM:   result_o = sum_w;
      SEL_SHIFT: result_o = shift_w;
      SEL_LT:    result_o = {{(XLEN-1){1'b0}}, lt_w};
      SEL_XOR:   result_o = op_a_i ^ op_b_i;
      SEL_OR:    result_o = op_a_i | op_b_i;
      SEL_AND:   result_o = op_a_i & op_b_i;
      default:   result_o = sum_w;
    endcase
  end

endmodule

// File: rtl/rv_alu_chk.sv
`timescale 1ns/1ps
module rv_alu_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] op_a_i,
  input logic [XLEN-1:0] op_b_i,
  input logic [2:0]      funct3_i,
  input logic            alt_i,
  input logic            imm_form_i,
  input logic [XLEN-1:0] result_o,
  input logic [XLEN-1:0] sum_w
);

  localparam int SHW = $clog2(XLEN);
  localparam int MSB = XLEN - 1;

  logic shamt_nz;
  assign shamt_nz = |op_b_i[SHW-1:0];

  always_comb begin
    // R4 / R5: compare results are a single bit
    a_r4_lt_bool: assert (!(funct3_i[2:1] == 2'b01) || result_o[MSB:1] == '0)
      else $error("less-than result wider than one bit");
    a_r5_sltu_order: assert (!(funct3_i == 3'b011) || result_o[0] == (op_a_i < op_b_i))
      else $error("unsigned compare wrong");
    a_r2_sub_self: assert (!(funct3_i == 3'b000 && alt_i && !imm_form_i && op_a_i == op_b_i)
                           || result_o == '0)
      else $error("x - x not zero");
    a_r3_imm_adds: assert (!(funct3_i == 3'b000 && imm_form_i) || result_o == sum_w)
      else $error("immediate form did not take adder output");
    a_r6_and_subset: assert (!(funct3_i == 3'b111) || (result_o & ~op_a_i) == '0)
      else $error("and set a bit absent from operand a");
    a_r7_sll_low_zero: assert (!(funct3_i == 3'b001 && shamt_nz) || result_o[0] == 1'b0)
      else $error("left shift filled low bit");
    a_r8_srl_top_zero: assert (!(funct3_i == 3'b101 && !alt_i && shamt_nz) || result_o[MSB] == 1'b0)
      else $error("logical right shift filled top bit");
    a_r9_sra_sign: assert (!(funct3_i == 3'b101 && alt_i) || result_o[MSB] == op_a_i[MSB])
      else $error("arithmetic right shift lost sign");
  end

endmodule

bind rv_alu rv_alu_chk #(.XLEN(XLEN)) u_chk (
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .funct3_i   (funct3_i),
  .alt_i      (alt_i),
  .imm_form_i (imm_form_i),
  .result_o   (result_o),
  .sum_w      (sum_w)
);

// File: tb/rv_alu_tb_top.sv
`timescale 1ns/1ps
module rv_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a, op_b;
  logic [2:0]  f3;
  logic        alt, imm;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rv_alu dut_i (
    .op_a_i     (op_a),
    .op_b_i     (op_b),
    .funct3_i   (f3),
    .alt_i      (alt),
    .imm_form_i (imm),
    .result_o   (result)
  );

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                        logic [2:0] op, logic al, logic im);
    int unsigned sh;
    sh = b % 32;
    case (op)
      3'd0: return (al && !im) ? a - b : a + b;
      3'd1: return a << sh;
      3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      3'd4: return a ^ b;
      3'd5: return al ? 32'($signed(a) >>> sh) : a >> sh;
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic string tag_of(logic [31:0] b, logic [2:0] op, logic al, logic im);
    case (op)
      3'd0: return (al && im) ? "R3" : (al ? "R2" : "R1");
      3'd1: return (b[31:5] != 0) ? "R10" : (al ? "R11" : "R7");
      3'd2: return al ? "R11" : "R4";
      3'd3: return al ? "R11" : "R5";
      3'd5: return (b[31:5] != 0) ? "R10" : (al ? "R9" : "R8");
      default: return al ? "R11" : "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h f3=%0d alt=%0b imm=%0b got %h exp %h",
               tag, op_a, op_b, f3, alt, imm, result, exp);
    end
  endtask

  task automatic run(logic [31:0] a, logic [31:0] b, logic [2:0] op, logic al, logic im);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; f3 = op; alt = al; imm = im;
    @(negedge clk);
    check(tag_of(b, op, al, im), model(a, b, op, al, im));
  endtask

  logic [31:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                               32'h7FFF_FFFF, 32'h0000_001F, 32'hFFFF_FFE0, 32'h0000_0020};

  initial begin
    op_a = '0; op_b = '0; f3 = '0; alt = 1'b0; imm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'h0);  // idle inputs: zero sum
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int op = 0; op < 8; op++)
          for (int m = 0; m < 4; m++)
            run(corners[i], corners[j], 3'(op), m[0], m[1]);

    for (int k = 0; k < 3000; k++)
      run($urandom, $urandom, 3'($urandom), 1'($urandom), 1'($urandom));

    // R12: same-cycle response without a clock edge
    @(negedge clk);
    op_a = 32'd5; op_b = 32'd7; f3 = 3'd0; alt = 1'b0; imm = 1'b0;
    #0.5;
    check("R12", 32'd12);
    op_a = 32'd100;
    #0.5;
    check("R12", 32'd107);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout exp done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule